// File: doc/BRIEF.md
# Mersenne-31 Field Arithmetic Unit

This block performs arithmetic modulo the Mersenne prime p = 2^31 - 1 on three 32-bit registers: an accumulator A, an operand B and a second multiplicand C. A host loads the registers through a parallel write port. It then issues an opcode with a one-cycle strobe. Every result goes back into A and can be read there, while B and C keep their values.

Addition, subtraction and clear take one cycle. Multiplication and multiply-accumulate run on a serial shift-and-add engine that handles one multiplier bit per cycle. That engine keeps its partial sum reduced below p at every step. The reduction uses the identity 2^31 ≡ 1 (mod p): the bits above position 30 are folded back onto the low 31 bits, and p is then subtracted at most once. No divider is needed. A busy flag covers the whole multi-cycle run. Operands stored raw, including values of p or above, are reduced before use, so every result written to A is canonical.

Top module: `mersenne_field_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, registers A, B and C are set to zero and `busy` is low from the next cycle on.
- R2: A write updates one register when `wr_en` is high, `busy` is low and `op_valid` is low at the edge. The target is chosen by `wr_sel`: 0 is A, 1 is B, 2 is C. The value 3, or a write made while busy or together with an opcode, changes no register.
- R3: Opcode values are 0x0 NOP, 0x1 ADD, 0x2 SUB, 0x3 MUL, 0x4 CLR and 0x5 MAC. NOP and the unused values 0x6 to 0xF change no register and do not raise `busy`.
- R4: ADD writes (A + B) mod p into A at the edge that accepts it, and `busy` stays low.
- R5: SUB writes (A - B) mod p into A in one cycle. When A < B it wraps by adding p, so the result lies in [0, p-1].
- R6: MUL raises `busy` at the edge that accepts it and holds it high for exactly 32 cycles. At the edge where `busy` falls, A receives (A × B) mod p.
- R7: MAC follows the timing of R6. It writes (A + B × C) mod p into A, using the value A held before the operation started.
- R8: CLR sets A, B and C to zero in one cycle.
- R9: Any register value of p or above enters an operation reduced modulo p, so a value equal to p acts as 0. The value left in A by ADD, SUB, MUL or MAC is always below p.
- R10: An opcode strobe presented while `busy` is high is ignored. It neither starts a new operation nor changes any register or the running result.
- R11: B and C are never changed by ADD, SUB, MUL, MAC or NOP, and they stay stable throughout a multi-cycle run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 A, 1 B, 2 C, 3 none |
| wr_data | input | 32 | Raw value to store |
| op_valid | input | 1 | Opcode strobe, one cycle |
| op_code | input | 4 | Operation code |
| busy | output | 1 | High while MUL or MAC is running |
| reg_a | output | 32 | Accumulator contents |
| reg_b | output | 32 | Operand B contents |
| reg_c | output | 32 | Operand C contents |

## Verification
The bench builds the unit with its default step count of 32. That count covers a full 31-bit multiplier plus one leading zero bit, so the extreme operands are reachable: p-1 squared, raw values equal to p, and raw values of 2^31 and above. With this count the exact 32-cycle busy window can be measured against a fixed expectation. Opcode strobes and register writes are injected partway through a run, which tests that they are ignored against the same reference model that predicts each result.

// File: rtl/mfu_pkg.sv
// Package: shared constants, opcode encoding and modular helpers for the
// Mersenne-31 field unit. Assumes operands passed to mod_add / mod_sub are
// already canonical (below PRIME).
package mfu_pkg;

    localparam int unsigned FIELD_W = 31;
    localparam int unsigned WORD_W  = FIELD_W + 1;
    localparam logic [WORD_W-1:0] PRIME = {1'b0, {FIELD_W{1'b1}}};

    typedef enum logic [3:0] {
        OPC_NOP = 4'h0,
        OPC_ADD = 4'h1,
        OPC_SUB = 4'h2,
        OPC_MUL = 4'h3,
        OPC_CLR = 4'h4,
        OPC_MAC = 4'h5
    } opc_e;

    // Fold bit 31 onto bits [30:0] (2^31 == 1 mod p), then one conditional subtract.
    function automatic logic [WORD_W-1:0] fold_reduce(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] s;
        s = {1'b0, x[FIELD_W-1:0]} + {{(WORD_W-1){1'b0}}, x[WORD_W-1]};
        if (s >= PRIME) s = s - PRIME;
        return s;
    endfunction

    // Modular sum of two canonical values; the raw sum stays below 2^32.
    function automatic logic [WORD_W-1:0] mod_add(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
        return fold_reduce(a + b);
    endfunction

    // Modular difference of two canonical values; wraps by adding p.
    function automatic logic [WORD_W-1:0] mod_sub(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
        logic [WORD_W-1:0] d;
        if (a >= b) d = a - b;
        else        d = a + PRIME - b;
        return d;
    endfunction

endpackage

// File: rtl/mfu_serial_mul.sv
// Serial modular multiplier: one multiplier bit per cycle, MSB first,
// double-and-add with the running sum folded below p each step.
// Assumes x_in and y_in are canonical and STEPS >= WORD_W so every bit of
// y_in is consumed. done is a one-cycle combinational flag on the last step;
// prod is valid only while done is high.
module mfu_serial_mul
    import mfu_pkg::*;
#(
    parameter int unsigned STEPS = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] x_in,
    input  logic [WORD_W-1:0] y_in,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] prod
);
    localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    logic              running;
    logic [CNT_W-1:0]  step_cnt;
    logic [WORD_W-1:0] acc_q, x_q, y_q;
    logic [WORD_W-1:0] dbl, acc_n;

    // Next partial sum: double the running value, add x when the current bit is set.
    always_comb begin
        dbl   = fold_reduce({acc_q[WORD_W-2:0], 1'b0});
        acc_n = y_q[WORD_W-1] ? mod_add(dbl, x_q) : dbl;
    end

    assign busy = running;
    assign done = running && (step_cnt == LAST);
    assign prod = acc_n;

    // Sequencer: load operands on start, step while running, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            step_cnt <= '0;
            acc_q    <= '0;
            x_q      <= '0;
            y_q      <= '0;
        end else if (start && !running) begin
            running  <= 1'b1;
            step_cnt <= '0;
            acc_q    <= '0;
            x_q      <= x_in;
            y_q      <= y_in;
        end else if (running) begin
            acc_q    <= acc_n;
            y_q      <= {y_q[WORD_W-2:0], 1'b0};
            step_cnt <= step_cnt + 1'b1;
            if (done) running <= 1'b0;
        end
    end

endmodule

// File: rtl/mfu_regs.sv
// Register file for A, B and C. Clear has top priority, then the result
// write into A, then the host write. Assumes the caller already blocks host
// writes during an operation; a select outside 0..NREGS-1 matches nothing.
module mfu_regs
    import mfu_pkg::*;
#(
    parameter int unsigned NREGS = 3,
    parameter int unsigned SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              res_we,
    input  logic [WORD_W-1:0] res_val,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] regs_q [NREGS]
);
    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        // Per-register update: reset/clear, result (A only), or host load.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                regs_q[gi] <= '0;
            end else if ((gi == 0) && res_we) begin
                regs_q[gi] <= res_val;
            end else if (wr_en && (wr_sel == SEL_W'(gi))) begin
                regs_q[gi] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mersenne_field_unit.sv
// Top of the Mersenne-31 field unit. Decodes the opcode strobe, does the
// one-cycle ADD/SUB/CLR, hands MUL/MAC to the serial multiplier and writes
// the result into A. Assumes op_valid is a one-cycle strobe; strobes seen
// while busy are dropped.
module mersenne_field_unit
    import mfu_pkg::*;
#(
    parameter int unsigned MUL_STEPS = WORD_W,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned OPC_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    output logic              busy,
    output logic [WORD_W-1:0] reg_a,
    output logic [WORD_W-1:0] reg_b,
    output logic [WORD_W-1:0] reg_c
);
    localparam int unsigned NREGS = 3;

    logic [WORD_W-1:0] regs_q [NREGS];
    logic [WORD_W-1:0] a_c, b_c, c_c;
    logic              accept, is_mul, is_mac, mul_start;
    logic              mac_q, mul_busy, mul_done;
    logic [WORD_W-1:0] mul_prod, mul_y;
    logic              clr, res_we, host_we;
    logic [WORD_W-1:0] res_val;

    assign reg_a = regs_q[0];
    assign reg_b = regs_q[1];
    assign reg_c = regs_q[2];
    assign busy  = mul_busy;

    // Canonical operands: raw stored values reduced below p.
    always_comb begin
        a_c = fold_reduce(reg_a);
        b_c = fold_reduce(reg_b);
        c_c = fold_reduce(reg_c);
    end

    // Opcode acceptance and multiplier launch.
    always_comb begin
        accept    = op_valid && !mul_busy;
        is_mul    = (op_code == OPC_W'(OPC_MUL));
        is_mac    = (op_code == OPC_W'(OPC_MAC));
        mul_start = accept && (is_mul || is_mac);
        mul_y     = is_mac ? c_c : a_c;
        host_we   = wr_en && !mul_busy && !op_valid;
    end

    // Remember which multi-cycle operation is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)         mac_q <= 1'b0;
        else if (mul_start) mac_q <= is_mac;
    end

    // Result selection for A and the clear strobe.
    always_comb begin
        res_we  = 1'b0;
        res_val = '0;
        clr     = 1'b0;
        if (mul_done) begin
            res_we  = 1'b1;
            res_val = mac_q ? mod_add(mul_prod, a_c) : mul_prod;
        end else if (accept) begin
            if (op_code == OPC_W'(OPC_ADD)) begin
                res_we  = 1'b1;
                res_val = mod_add(a_c, b_c);
            end else if (op_code == OPC_W'(OPC_SUB)) begin
                res_we  = 1'b1;
                res_val = mod_sub(a_c, b_c);
            end else if (op_code == OPC_W'(OPC_CLR)) begin
                clr = 1'b1;
            end
        end
    end

    mfu_serial_mul #(.STEPS(MUL_STEPS)) mul_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .x_in  (b_c),
        .y_in  (mul_y),
        .busy  (mul_busy),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    mfu_regs #(.NREGS(NREGS), .SEL_W(SEL_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .res_we  (res_we),
        .res_val (res_val),
        .wr_en   (host_we),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

endmodule

// File: rtl/mfu_checker.sv
// Checker for the Mersenne-31 field unit, attached by bind. Counts busy
// cycles itself so the 32-cycle window needs no deep $past.
module mfu_checker
    import mfu_pkg::*;
#(
    parameter int unsigned STEPS = WORD_W,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned OPC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OPC_W-1:0]  op_code,
    input logic              busy,
    input logic [WORD_W-1:0] reg_a,
    input logic [WORD_W-1:0] reg_b,
    input logic [WORD_W-1:0] reg_c
);
    localparam int unsigned BC_W = $clog2(STEPS + 1) + 1;

    logic [BC_W-1:0] busy_cnt;
    logic            acc_op;

    assign acc_op = op_valid && !busy;

    // Busy-cycle counter: number of busy cycles seen so far in this run.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < BC_W'(STEPS)));                               // R6
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(busy_cnt) == BC_W'(STEPS - 1)));            // R6
    AST_MUL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op && (op_code == OPC_W'(OPC_MUL) || op_code == OPC_W'(OPC_MAC))) |=> busy); // R7
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op && (op_code == OPC_W'(OPC_ADD) || op_code == OPC_W'(OPC_SUB)))
        |=> (!busy && reg_a < PRIME));                                     // R4
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op && op_code == OPC_W'(OPC_CLR))
        |=> (reg_a == '0 && reg_b == '0 && reg_c == '0));                  // R8
    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op && (op_code == OPC_W'(OPC_NOP) || op_code > OPC_W'(OPC_MAC)))
        |=> ($stable(reg_a) && $stable(reg_b) && $stable(reg_c) && !busy)); // R3
    AST_HOLD_BC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(reg_b) && $stable(reg_c)));                      // R11
    AST_CANON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (reg_a < PRIME));                                  // R9
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt < BC_W'(STEPS - 1)) |=> (busy && $stable(reg_a))); // R10

endmodule

bind mersenne_field_unit mfu_checker #(
    .STEPS (MUL_STEPS),
    .SEL_W (SEL_W),
    .OPC_W (OPC_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .busy     (busy),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .reg_c    (reg_c)
);

// File: tb/mersenne_field_unit_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks update a reference model and push expected
// register snapshots; a monitor pops and compares them at falling edges.
module mersenne_field_unit_tb_top;

    localparam longint unsigned P = 64'h7FFF_FFFF;
    localparam int WATCHDOG_CYC = 150000;

    typedef struct {
        string          req;
        logic [31:0]    a, b, c;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        busy;
    logic [31:0] reg_a, reg_b, reg_c;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];
    longint unsigned ma = 0, mb = 0, mc = 0;

    always #2 clk = ~clk;

    mersenne_field_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .op_valid(op_valid), .op_code(op_code),
        .busy(busy), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c)
    );

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic longint unsigned red(input longint unsigned x);
        return x % P;
    endfunction

    task automatic expect_state(input string req);
        exp_t e;
        e.req = req; e.a = ma[31:0]; e.b = mb[31:0]; e.c = mc[31:0];
        sb_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare every queued expectation with the register outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, "reg_a", reg_a, e.a);
                chk(e.req, "reg_b", reg_b, e.b);
                chk(e.req, "reg_c", reg_c, e.c);
                chk(e.req, "busy",  busy,  0);
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 2'd0) ma = d;
        else if (sel == 2'd1) mb = d;
        else if (sel == 2'd2) mc = d;
    endtask

    task automatic model_op(input logic [3:0] code);
        case (code)
            4'h1: ma = (red(ma) + red(mb)) % P;
            4'h2: ma = (red(ma) + P - red(mb)) % P;
            4'h3: ma = (red(ma) * red(mb)) % P;
            4'h4: begin ma = 0; mb = 0; mc = 0; end
            4'h5: ma = (red(ma) + (red(mb) * red(mc)) % P) % P;
            default: ;
        endcase
    endtask

    // One-cycle operation; checks busy never rises.
    task automatic op1(input logic [3:0] code, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_code = code;
        @(negedge clk);
        op_valid = 1'b0;
        chk(req, "busy after one-cycle op", busy, 0);
        model_op(code);
        expect_state(req);
    endtask

    // Multi-cycle operation; measures busy length, optionally injects
    // an opcode strobe and a host write in the middle of the run.
    task automatic opm(input logic [3:0] code, input bit inject, input string req);
        int n;
        @(negedge clk);
        op_valid = 1'b1; op_code = code;
        @(negedge clk);
        op_valid = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            n++;
            if (inject && n == 5) begin
                op_valid = 1'b1; op_code = 4'h4;
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h1234_5678;
            end else begin
                op_valid = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
        end
        op_valid = 1'b0; wr_en = 1'b0;
        chk(req, "busy cycle count", n, 32);
        model_op(code);
        expect_state(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        expect_state("R1");

        // R2: loads, select 3 ignored, write with opcode ignored
        wr(2'd0, 32'd5); wr(2'd1, 32'd3); wr(2'd2, 32'd7);
        expect_state("R2");
        wr(2'd3, 32'hDEAD_BEEF);
        expect_state("R2");
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'd99; op_valid = 1'b1; op_code = 4'h0;
        @(negedge clk);
        wr_en = 1'b0; op_valid = 1'b0;
        expect_state("R2");

        // R4: simple and wrapping add
        op1(4'h1, "R4");
        wr(2'd0, 32'h7FFF_FFFE); wr(2'd1, 32'd5);
        op1(4'h1, "R4");
        // R9: operands equal to p act as zero
        wr(2'd0, 32'h7FFF_FFFF); wr(2'd1, 32'h7FFF_FFFF);
        op1(4'h1, "R9");
        chk("R9", "A after p+p", reg_a, 0);

        // R5: subtraction, plain and wrapping
        wr(2'd0, 32'd10); wr(2'd1, 32'd4);
        op1(4'h2, "R5");
        wr(2'd0, 32'd3); wr(2'd1, 32'd5);
        op1(4'h2, "R5");
        chk("R5", "A after 3-5", reg_a, 32'h7FFF_FFFD);

        // R3: NOP and unused opcodes leave state alone
        op1(4'h0, "R3");
        op1(4'h9, "R3");
        op1(4'hF, "R3");

        // R6: multiply small and extreme
        wr(2'd0, 32'd6); wr(2'd1, 32'd7);
        opm(4'h3, 1'b0, "R6");
        chk("R6", "A after 6*7", reg_a, 42);
        wr(2'd0, 32'h7FFF_FFFE); wr(2'd1, 32'h7FFF_FFFE);
        opm(4'h3, 1'b0, "R6");
        chk("R6", "A after (p-1)^2", reg_a, 1);
        // R9: raw values at or above 2^31 are reduced first
        wr(2'd0, 32'h8000_0000); wr(2'd1, 32'hFFFF_FFFF);
        opm(4'h3, 1'b0, "R9");
        wr(2'd0, 32'h1357_9BDF); wr(2'd1, 32'h7654_3210);
        opm(4'h3, 1'b0, "R6");

        // R7: multiply-accumulate
        wr(2'd0, 32'd10); wr(2'd1, 32'd3); wr(2'd2, 32'd4);
        opm(4'h5, 1'b0, "R7");
        chk("R7", "A after 10+3*4", reg_a, 22);
        wr(2'd0, 32'h7FFF_FFF0); wr(2'd1, 32'h6ABC_DEF1); wr(2'd2, 32'hF00D_CAFE);
        opm(4'h5, 1'b0, "R7");

        // R10/R11: strobe and write during a run are ignored; B, C unchanged
        wr(2'd0, 32'h0BAD_F00D); wr(2'd1, 32'h0001_0003); wr(2'd2, 32'd17);
        opm(4'h5, 1'b1, "R10");
        opm(4'h3, 1'b1, "R11");

        // R8: clear
        op1(4'h4, "R8");

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule